// File: doc/BRIEF.md
# Multi-Clock Power-Down Controller

This block stops a group of output clocks cleanly when an asynchronous, active-low power-down request arrives. It also shuts the oscillator and PLL down once those outputs are parked. When the request is released, it brings everything back up after a lock wait. Each output clock has its own falling-edge pipeline. That pipeline synchronizes the request and a run permit, then registers an enable that gates the clock through an AND. So an output always completes its cycle in progress, parks low, and later restarts with a full-width high phase.

A sequencer in the reference clock domain does three jobs:
- It times the oscillator and PLL shutdown with a fixed count of reference cycles after it sees the request.
- It holds the outputs off during a parameterized lock interval after power-on and after every wake-up.
- It lets an early release cancel a shutdown that has not yet reached the oscillator, without a new lock wait.

A strap latch captures configuration pin values once after power-on reset and then reports that the pins may be driven as outputs. A power-down never touches the latch.

The request must stay asserted for at least 2+SHUT_CYCLES reference periods. Within that time, 3 periods of the slowest output clock must fit, so every output is parked before the oscillator stops. The latency figures assume SYNC_STAGES = 2 and SHUT_CYCLES of at least 2.

Top module: `clkstop_ctrl`

## Requirements
- R1: While `por_n` is low, every `gated_clk` bit is 0, `strap_value` is 0, `strap_drive_en` is 0, and `osc_enable` and `pll_enable` are 1.
- R2: After `por_n` rises, no `gated_clk` bit rises for at least LOCK_CYCLES reference periods; after that, every output runs.
- R3: After `pd_req_n` falls, each output's last falling edge comes between 2 and 3 of its own periods later, and the output shows a rising edge after the request before it parks low.
- R4: Every high phase of a `gated_clk` bit lasts a full half period of its source, and every low phase lasts at least a half period, across stops and restarts.
- R5: `osc_enable` and `pll_enable` go to 0 on the (2+SHUT_CYCLES)-th rising edge of `ref_clk`, counting the first edge that samples `pd_req_n` low. While `osc_enable` is 0, all outputs are low.
- R6: After a release, `osc_enable` and `pll_enable` return to 1 on the 3rd `ref_clk` rising edge that samples `pd_req_n` high. Outputs stay low for at least LOCK_CYCLES+2 reference periods from the release, then run.
- R7: A release that arrives before the enables drop keeps `osc_enable` high throughout, and the outputs resume without a lock wait.
- R8: A request during a lock wait drops `osc_enable` and `pll_enable` on the 3rd `ref_clk` edge that samples it; the release that follows starts a full lock wait.
- R9: `strap_value` takes the value on `strap_pin_in` shortly after `por_n` rises. At the same edge, `strap_drive_en` changes from 0 (pins are inputs) to 1 (pins are driven) and stays 1.
- R10: Once captured, `strap_value` stays unchanged through later pin changes and power-down cycles; only a new power-on reset captures again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock for the sequencer and strap latch |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| pd_req_n | input | 1 | Asynchronous active-low power-down request |
| src_clk | input | NUM_CLK | Free-running source clocks, one per output |
| strap_pin_in | input | STRAP_W | Strap pin levels seen while the pins are inputs |
| gated_clk | output | NUM_CLK | Gated output clocks |
| osc_enable | output | 1 | Oscillator enable, 1 = running |
| pll_enable | output | 1 | PLL enable, 1 = running |
| strap_value | output | STRAP_W | Captured strap configuration |
| strap_drive_en | output | 1 | Strap pin direction, 1 = drive as output |

## Verification
The hardest situation to reach from the ports is the cancelled shutdown. The release has to land after the sequencer has already left the run state but before its timer expires. The bench gets there by asserting and releasing the request on consecutive reference falling edges, so the release is sampled while the shutdown timer is still counting. The stop-latency window also depends on the phase of the request against three unrelated output clocks. The bench covers that by sweeping the request offset in sub-nanosecond steps across repeated power-down cycles.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

  // Sequencer states in the reference clock domain.
  typedef enum logic [1:0] {
    SEQ_LOCK = 2'd0,  // oscillator on, waiting for PLL lock
    SEQ_RUN  = 2'd1,  // outputs permitted
    SEQ_SHUT = 2'd2,  // request seen, shutdown timer running
    SEQ_OFF  = 2'd3   // oscillator and PLL disabled
  } seq_state_e;

endpackage

// File: rtl/cs_sync.sv
// Multi-stage level synchronizer with asynchronous reset.
// FALLING selects the capture edge of the destination clock.
module cs_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b0,
  parameter bit FALLING   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;

  generate
    if (FALLING) begin : g_fall
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d};
      end
    end else begin : g_rise
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/cs_out_gate.sv
// One output clock domain: reset release, request and permit
// synchronizers, and a falling-edge enable that gates the clock.
module cs_out_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic src_clk,
  input  logic por_n,
  input  logic pd_req_n,
  input  logic permit,
  output logic gated
);

  logic local_rst_n;
  logic run_req_s;
  logic permit_s;
  logic en_d;
  logic en_q;

  // Reset is asserted asynchronously and released on a falling edge.
  cs_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0), .FALLING(1'b1)) u_rst (
    .clk(src_clk), .rst_n(por_n), .d(1'b1), .q(local_rst_n)
  );

  // Reset value 0 means "stopped" for both synchronized levels.
  cs_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0), .FALLING(1'b1)) u_req (
    .clk(src_clk), .rst_n(local_rst_n), .d(pd_req_n), .q(run_req_s)
  );

  cs_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0), .FALLING(1'b1)) u_permit (
    .clk(src_clk), .rst_n(local_rst_n), .d(permit), .q(permit_s)
  );

  // The enable changes only on falling edges, while the source is low.
  // A request seen at one falling edge lets the next rise and fall pass,
  // so the output completes a full cycle before it parks.
  always_comb begin
    en_d = run_req_s & permit_s;
  end

  always_ff @(negedge src_clk or negedge local_rst_n) begin
    if (!local_rst_n) en_q <= 1'b0;
    else              en_q <= en_d;
  end

  assign gated = src_clk & en_q;

endmodule

// File: rtl/cs_ref_seq.sv
// Reference-domain sequencer: lock wait, shutdown timer, oscillator and
// PLL enables, and the run permit sent to every output domain.
module cs_ref_seq
  import clkstop_pkg::*;
#(
  parameter int LOCK_CYCLES = 375000,
  parameter int SHUT_CYCLES = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic pd_req_n,
  output logic permit,
  output logic osc_en,
  output logic pll_en
);

  localparam int CNT_MAX = (LOCK_CYCLES > SHUT_CYCLES) ? LOCK_CYCLES : SHUT_CYCLES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] LOCK_LAST = CNT_W'(LOCK_CYCLES - 1);
  localparam logic [CNT_W-1:0] SHUT_LAST = CNT_W'(SHUT_CYCLES - 1);
  localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);

  logic       req_ok;
  seq_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic       permit_q, osc_q, pll_q;

  cs_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0), .FALLING(1'b0)) u_req (
    .clk(ref_clk), .rst_n(rst_n), .d(pd_req_n), .q(req_ok)
  );

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      SEQ_LOCK: begin
        if (!req_ok) begin
          state_d = SEQ_OFF;
          cnt_d   = '0;
        end else if (cnt_q == LOCK_LAST) begin
          state_d = SEQ_RUN;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_ONE;
        end
      end
      SEQ_RUN: begin
        if (!req_ok) begin
          state_d = SEQ_SHUT;
          cnt_d   = CNT_ONE;
        end
      end
      SEQ_SHUT: begin
        // A release wins over timer expiry: the PLL is still running.
        if (req_ok) begin
          state_d = SEQ_RUN;
          cnt_d   = '0;
        end else if (cnt_q == SHUT_LAST) begin
          state_d = SEQ_OFF;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_ONE;
        end
      end
      default: begin
        if (req_ok) begin
          state_d = SEQ_LOCK;
          cnt_d   = '0;
        end
      end
    endcase
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SEQ_LOCK;
      cnt_q    <= '0;
      permit_q <= 1'b0;
      osc_q    <= 1'b1;
      pll_q    <= 1'b1;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      permit_q <= (state_d == SEQ_RUN) || (state_d == SEQ_SHUT);
      osc_q    <= (state_d != SEQ_OFF);
      pll_q    <= (state_d != SEQ_OFF);
    end
  end

  assign permit = permit_q;
  assign osc_en = osc_q;
  assign pll_en = pll_q;

endmodule

// File: rtl/cs_strap_latch.sv
// Captures strap pins once after power-on reset, then flips pin direction.
module cs_strap_latch #(
  parameter int STRAP_W = 4
) (
  input  logic               ref_clk,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] pins,
  output logic [STRAP_W-1:0] value,
  output logic               drive_en
);

  logic [STRAP_W-1:0] value_q;
  logic               taken_q;
  logic               capture_en;

  always_comb begin
    capture_en = !taken_q;
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      value_q <= '0;
      taken_q <= 1'b0;
    end else if (capture_en) begin
      value_q <= pins;
      taken_q <= 1'b1;
    end
  end

  assign value    = value_q;
  assign drive_en = taken_q;

endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
  import clkstop_pkg::*;
#(
  parameter int NUM_CLK     = 3,
  parameter int LOCK_CYCLES = 375000,
  parameter int SHUT_CYCLES = 3,
  parameter int SYNC_STAGES = 2,
  parameter int STRAP_W     = 4
) (
  input  logic               ref_clk,
  input  logic               por_n,
  input  logic               pd_req_n,
  input  logic [NUM_CLK-1:0] src_clk,
  input  logic [STRAP_W-1:0] strap_pin_in,
  output logic [NUM_CLK-1:0] gated_clk,
  output logic               osc_enable,
  output logic               pll_enable,
  output logic [STRAP_W-1:0] strap_value,
  output logic               strap_drive_en
);

  logic ref_rst_n;
  logic permit;

  cs_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0), .FALLING(1'b0)) u_ref_rst (
    .clk(ref_clk), .rst_n(por_n), .d(1'b1), .q(ref_rst_n)
  );

  cs_ref_seq #(
    .LOCK_CYCLES(LOCK_CYCLES),
    .SHUT_CYCLES(SHUT_CYCLES),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_seq (
    .ref_clk (ref_clk),
    .rst_n   (ref_rst_n),
    .pd_req_n(pd_req_n),
    .permit  (permit),
    .osc_en  (osc_enable),
    .pll_en  (pll_enable)
  );

  cs_strap_latch #(.STRAP_W(STRAP_W)) u_strap (
    .ref_clk (ref_clk),
    .rst_n   (ref_rst_n),
    .pins    (strap_pin_in),
    .value   (strap_value),
    .drive_en(strap_drive_en)
  );

  generate
    for (genvar i = 0; i < NUM_CLK; i++) begin : g_dom
      cs_out_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
        .src_clk (src_clk[i]),
        .por_n   (por_n),
        .pd_req_n(pd_req_n),
        .permit  (permit),
        .gated   (gated_clk[i])
      );
    end
  endgenerate

endmodule

// File: rtl/clkstop_ctrl_chk.sv
module clkstop_ctrl_chk #(
  parameter int NUM_CLK = 3,
  parameter int STRAP_W = 4
) (
  input logic               ref_clk,
  input logic               por_n,
  input logic               pd_req_n,
  input logic [NUM_CLK-1:0] gated_clk,
  input logic               osc_enable,
  input logic [STRAP_W-1:0] strap_value,
  input logic               strap_drive_en
);

  // R10: once captured, the strap value never moves until power-on reset.
  assert_strap_hold_R10: assert property (@(posedge ref_clk) disable iff (!por_n)
    strap_drive_en |=> $stable(strap_value));

  // R9: pin direction flips to output once and stays there.
  assert_drive_sticky_R9: assert property (@(posedge ref_clk) disable iff (!por_n)
    strap_drive_en |=> strap_drive_en);

  // R5: with the oscillator off, every output is parked low.
  assert_off_parked_R5: assert property (@(posedge ref_clk) disable iff (!por_n)
    !osc_enable |-> (gated_clk == '0));

  // R6: a wake-up only follows a released request, with outputs still low.
  assert_wake_quiet_R6: assert property (@(posedge ref_clk) disable iff (!por_n)
    $rose(osc_enable) |-> ((gated_clk == '0) && $past(pd_req_n, 2)));

endmodule

bind clkstop_ctrl clkstop_ctrl_chk #(.NUM_CLK(NUM_CLK), .STRAP_W(STRAP_W)) u_chk (
  .ref_clk       (ref_clk),
  .por_n         (por_n),
  .pd_req_n      (pd_req_n),
  .gated_clk     (gated_clk),
  .osc_enable    (osc_enable),
  .strap_value   (strap_value),
  .strap_drive_en(strap_drive_en)
);

// File: tb/clkstop_ctrl_bench.sv
`timescale 1ns/1ps
module clkstop_ctrl_bench;

  localparam int NCLK = 3;
  localparam int LOCK = 40;
  localparam int SHUT = 3;
  localparam int SW   = 4;
  localparam real TREF = 8.0;

  logic ref_clk = 1'b0;
  logic c0 = 1'b0, c1 = 1'b0, c2 = 1'b0;
  logic por_n = 1'b0;
  logic pd_req_n = 1'b1;
  logic [SW-1:0] pins = 4'hA;
  logic [NCLK-1:0] src;
  logic [NCLK-1:0] gated;
  logic osc_en, pll_en, drive_en;
  logic [SW-1:0] strap_val;

  int checks = 0;
  int errors = 0;

  assign src = {c2, c1, c0};

  clkstop_ctrl #(
    .NUM_CLK(NCLK), .LOCK_CYCLES(LOCK), .SHUT_CYCLES(SHUT),
    .SYNC_STAGES(2), .STRAP_W(SW)
  ) u_clkstop_ctrl (
    .ref_clk(ref_clk), .por_n(por_n), .pd_req_n(pd_req_n), .src_clk(src),
    .strap_pin_in(pins), .gated_clk(gated), .osc_enable(osc_en),
    .pll_enable(pll_en), .strap_value(strap_val), .strap_drive_en(drive_en)
  );

  // 125 MHz reference and three unrelated source clocks.
  initial forever #4 ref_clk = ~ref_clk;
  initial begin #0.7; forever #2.5 c0 = ~c0; end
  initial begin #1.3; forever #3.5 c1 = ~c1; end
  initial begin #2.9; forever #5.5 c2 = ~c2; end

  function automatic real half_of(input int i);
    case (i)
      0: return 2.5;
      1: return 3.5;
      default: return 5.5;
    endcase
  endfunction

  // Edge monitor: pulse widths (R4), edge times and first rise after arming.
  logic [NCLK-1:0] prev_g = '0;
  realtime last_rise [NCLK] = '{-100.0, -100.0, -100.0};
  realtime last_fall [NCLK] = '{-100.0, -100.0, -100.0};
  realtime first_rise [NCLK] = '{0.0, 0.0, 0.0};
  bit armed [NCLK] = '{1'b0, 1'b0, 1'b0};
  int runt [NCLK] = '{0, 0, 0};

  always @(gated) begin
    for (int i = 0; i < NCLK; i++) begin
      if (gated[i] !== prev_g[i]) begin
        if (gated[i] === 1'b1) begin
          if ($realtime - last_fall[i] < half_of(i) - 0.01) runt[i]++;
          last_rise[i] = $realtime;
          if (armed[i]) begin
            first_rise[i] = $realtime;
            armed[i] = 1'b0;
          end
        end else begin
          if ($realtime - last_rise[i] < half_of(i) - 0.01) runt[i]++;
          last_fall[i] = $realtime;
        end
      end
    end
    prev_g = gated;
  end

  task automatic chk(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic arm_all();
    for (int i = 0; i < NCLK; i++) armed[i] = 1'b1;
  endtask

  realtime t_req, t_rel;

  // Power-down with the request placed d ns after a reference falling edge.
  task automatic do_request(input real d, input logic [SW-1:0] exp_strap);
    @(negedge ref_clk);
    #(d);
    pd_req_n = 1'b0;
    t_req = $realtime;
    repeat (SHUT + 1) @(posedge ref_clk);
    #1;
    chk(osc_en === 1'b1 && pll_en === 1'b1,
        $sformatf("R5 enables early: actual osc=%0b pll=%0b expected 1 1", osc_en, pll_en));
    @(posedge ref_clk);
    #1;
    chk(osc_en === 1'b0 && pll_en === 1'b0,
        $sformatf("R5 enables late: actual osc=%0b pll=%0b expected 0 0", osc_en, pll_en));
    repeat (8) @(posedge ref_clk);
    #1;
    for (int i = 0; i < NCLK; i++) begin
      real lat;
      lat = (last_fall[i] - t_req) / (2.0 * half_of(i));
      chk(gated[i] === 1'b0,
          $sformatf("R3 clk%0d not parked: actual %0b expected 0", i, gated[i]));
      chk(lat >= 2.0 - 0.001 && lat <= 3.0 + 0.001,
          $sformatf("R3 clk%0d stop latency: actual %f periods expected 2..3", i, lat));
      chk(last_rise[i] > t_req,
          $sformatf("R3 clk%0d no full cycle: last rise %f request %f", i, last_rise[i], t_req));
    end
    chk(strap_val === exp_strap,
        $sformatf("R10 strap during power-down: actual %h expected %h", strap_val, exp_strap));
  endtask

  // Release with full lock wait.
  task automatic do_release(input real d, input string tag, input logic [SW-1:0] exp_strap);
    @(negedge ref_clk);
    #(d);
    pd_req_n = 1'b1;
    t_rel = $realtime;
    arm_all();
    repeat (2) @(posedge ref_clk);
    #1;
    chk(osc_en === 1'b0,
        $sformatf("%s wake early: actual osc=%0b expected 0", tag, osc_en));
    @(posedge ref_clk);
    #1;
    chk(osc_en === 1'b1 && pll_en === 1'b1,
        $sformatf("%s wake late: actual osc=%0b pll=%0b expected 1 1", tag, osc_en, pll_en));
    repeat (LOCK + 12) @(posedge ref_clk);
    #1;
    for (int i = 0; i < NCLK; i++) begin
      chk(!armed[i] && first_rise[i] > t_rel + (LOCK + 2) * TREF
          && first_rise[i] < t_rel + (LOCK + 3) * TREF + 45.0,
          $sformatf("%s clk%0d restart: actual rise at %f after release, expected %f..%f",
                    tag, i, first_rise[i] - t_rel, (LOCK + 2) * TREF,
                    (LOCK + 3) * TREF + 45.0));
    end
    chk(strap_val === exp_strap,
        $sformatf("R10 strap after wake: actual %h expected %h", strap_val, exp_strap));
  endtask

  initial begin
    #20;
    // R1: reset state.
    chk(gated === '0 && strap_val === '0 && drive_en === 1'b0,
        $sformatf("R1 reset outputs: actual gated=%b strap=%h drive=%0b expected 0 0 0",
                  gated, strap_val, drive_en));
    chk(osc_en === 1'b1 && pll_en === 1'b1,
        $sformatf("R1 reset enables: actual osc=%0b pll=%0b expected 1 1", osc_en, pll_en));

    // R2: power-on lock wait.
    @(negedge ref_clk);
    #0.3;
    por_n = 1'b1;
    t_rel = $realtime;
    arm_all();
    repeat (LOCK + 15) @(posedge ref_clk);
    #1;
    for (int i = 0; i < NCLK; i++) begin
      chk(!armed[i] && first_rise[i] > t_rel + LOCK * TREF,
          $sformatf("R2 clk%0d first rise: actual %f after reset, expected > %f",
                    i, first_rise[i] - t_rel, LOCK * TREF));
    end

    // R9 capture, then R10 pin change ignored.
    chk(strap_val === 4'hA && drive_en === 1'b1,
        $sformatf("R9 capture: actual strap=%h drive=%0b expected a 1", strap_val, drive_en));
    pins = 4'h5;
    repeat (4) @(posedge ref_clk);
    #1;
    chk(strap_val === 4'hA,
        $sformatf("R10 pin change: actual %h expected a", strap_val));

    // Sweep the request phase over the output clocks.
    for (int k = 0; k < 8; k++) begin
      do_request(0.3 + k * 0.45, 4'hA);
      do_release(0.2 + k * 0.4, "R6", 4'hA);
    end

    // R7: release before the enables drop.
    begin
      int osc_drops;
      osc_drops = 0;
      @(negedge ref_clk);
      #0.3;
      pd_req_n = 1'b0;
      @(negedge ref_clk);
      #0.3;
      pd_req_n = 1'b1;
      t_rel = $realtime;
      arm_all();
      for (int c = 0; c < 12; c++) begin
        @(posedge ref_clk);
        #1;
        if (osc_en !== 1'b1) osc_drops++;
      end
      chk(osc_drops == 0,
          $sformatf("R7 oscillator dropped: actual %0d low samples expected 0", osc_drops));
      for (int i = 0; i < NCLK; i++) begin
        chk(!armed[i] && first_rise[i] < t_rel + 12 * TREF,
            $sformatf("R7 clk%0d resume: actual armed=%0b rise %f expected < %f",
                      i, armed[i], first_rise[i] - t_rel, 12 * TREF));
      end
    end

    // R8: request during a lock wait.
    do_request(1.1, 4'hA);
    @(negedge ref_clk);
    #0.5;
    pd_req_n = 1'b1;
    repeat (8) @(posedge ref_clk);
    #1;
    chk(osc_en === 1'b1 && gated === '0,
        $sformatf("R8 in lock wait: actual osc=%0b gated=%b expected 1 0", osc_en, gated));
    @(negedge ref_clk);
    #0.4;
    pd_req_n = 1'b0;
    repeat (2) @(posedge ref_clk);
    #1;
    chk(osc_en === 1'b1,
        $sformatf("R8 early drop: actual osc=%0b expected 1", osc_en));
    @(posedge ref_clk);
    #1;
    chk(osc_en === 1'b0 && pll_en === 1'b0,
        $sformatf("R8 drop on third edge: actual osc=%0b pll=%0b expected 0 0", osc_en, pll_en));
    repeat (4) @(posedge ref_clk);
    do_release(0.6, "R8", 4'hA);

    // R4: no runt pulses in any of the above.
    for (int i = 0; i < NCLK; i++) begin
      chk(runt[i] == 0,
          $sformatf("R4 clk%0d short phases: actual %0d expected 0", i, runt[i]));
    end

    // R1 and R9 again on a second power-on with new pins.
    @(negedge ref_clk);
    por_n = 1'b0;
    pins = 4'h3;
    #20;
    chk(gated === '0 && strap_val === '0 && drive_en === 1'b0,
        $sformatf("R1 second reset: actual gated=%b strap=%h drive=%0b expected 0 0 0",
                  gated, strap_val, drive_en));
    @(negedge ref_clk);
    #0.3;
    por_n = 1'b1;
    repeat (10) @(posedge ref_clk);
    #1;
    chk(strap_val === 4'h3 && drive_en === 1'b1,
        $sformatf("R10 recapture on power-on: actual strap=%h drive=%0b expected 3 1",
                  strap_val, drive_en));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * TREF);
    checks++;
    errors++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule